// File: doc/BRIEF.md
# Timer/Counter with Capture

A timer peripheral of configurable width with two ways of counting. In timer mode it counts ticks of a reference. The reference is one of two clock-enable inputs (a 16 MHz strobe or a 1 MHz strobe), divided down by a power-of-two prescaler. In counter mode it counts software strobes written to a count task register instead. Software controls the block through a single-cycle write port and a combinational read port. The write port triggers tasks (start, stop, count, clear, shutdown and one capture per channel) and sets mode, prescaler and reference selection.

Each capture/compare channel holds a value. A capture task loads the live count into that value. When an increment lands on that value, a sticky match flag is set. Interrupt enables are set and cleared through separate write-1 registers, and one interrupt line goes high while any enabled flag is set. Stopping the block pauses the count, and a later start resumes from the held value.

Top module: `tmr_capture_timer`

## Requirements
- R1: After reset the count is 0 and the block is stopped. All channel values, match flags and interrupt enables are 0, mode reads 0 (timer), prescaler reads 0, reference select reads 0 (16 MHz strobe), and `irq` is low.
- R2: In timer mode (mode register 0x22 bit0 = 0) the count rises by one for every 2^P strobes of the selected reference while running. P is the prescaler at 0x23. The reference select at 0x24 picks the strobe: bit0 = 0 takes `ref16_en`, bit0 = 1 takes `ref1_en`. Strobes of the other reference have no effect.
- R3: In counter mode (mode bit0 = 1) each write of bit0 = 1 to the count task (0x02) raises the count by one while running, and reference strobes have no effect. In timer mode the count task has no effect.
- R4: A write to the stop task (0x01) pauses the count, and no input changes it while stopped. A later write to the start task (0x00) resumes counting from the held value.
- R5: A write to capture task n (0x08+n) copies the count into channel n, which reads back at 0x28+n. If an increment happens in the same cycle, the captured value is the count before the increment.
- R6: When an increment produces a count equal to channel n, the match flag n (read bit0 at 0x10+n) is set in that same clock edge. The flag stays set until software writes 0 to 0x10+n. Writing 1 there has no effect.
- R7: `irq` is high exactly while some match flag has its enable set. Writing 1s to 0x20 sets enable bits and writing 1s to 0x21 clears them. Both addresses read back the enable vector.
- R8: A write to the clear task (0x03) sets the count and the prescaler phase to 0 without changing whether the block runs.
- R9: A write to the shutdown task (0x04) stops the block and sets the count to 0. A later start counts up from 0.
- R10: The count wraps from its all-ones value to 0, and that step can raise a match on a channel holding 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref16_en | input | 1 | One-cycle strobe at the 16 MHz reference rate |
| ref1_en | input | 1 | One-cycle strobe at the 1 MHz reference rate |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with an 8-bit count, four channels and a 4-bit prescaler exponent. The narrow count makes the wrap from 255 to 0 reachable with a few hundred count-task writes, so the wrap match on a channel holding 0 can be checked. The full prescaler range stays in place, and the bench uses exponents 0 and 2 to check whole division. It also checks that a capture and a reference tick landing in the same cycle keep the pre-increment value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  // register word addresses
  localparam logic [ADDR_W-1:0] ADR_START   = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_STOP    = 8'h01;
  localparam logic [ADDR_W-1:0] ADR_COUNT   = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_CLEAR   = 8'h03;
  localparam logic [ADDR_W-1:0] ADR_SHUT    = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_CAP     = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_EVT     = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_IEN_SET = 8'h20;
  localparam logic [ADDR_W-1:0] ADR_IEN_CLR = 8'h21;
  localparam logic [ADDR_W-1:0] ADR_MODE    = 8'h22;
  localparam logic [ADDR_W-1:0] ADR_PRESC   = 8'h23;
  localparam logic [ADDR_W-1:0] ADR_REFSEL  = 8'h24;
  localparam logic [ADDR_W-1:0] ADR_CC      = 8'h28;

  typedef enum logic {
    MODE_TIMER   = 1'b0,
    MODE_COUNTER = 1'b1
  } tmr_mode_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic cnt;
    logic clr;
    logic shut;
  } tmr_task_s;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             ref_sel,
  input  logic             ref16_en,
  input  logic             ref1_en,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);

  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] lim;
  logic             ref_pulse;

  assign ref_pulse = ref_sel ? ref1_en : ref16_en;
  assign lim       = ~({DIV_W{1'b1}} << presc);

  always_comb begin
    div_d = div_q;
    tick  = 1'b0;
    if (restart) begin
      div_d = '0;
    end else if (run && ref_pulse) begin
      if (div_q >= lim) begin
        tick  = 1'b1;
        div_d = '0;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_task_s        tsk,
  input  tmr_mode_e        mode,
  input  logic             tick,
  output logic             run_q,
  output logic [CNT_W-1:0] count_q,
  output logic             inc_fire,
  output logic [CNT_W-1:0] count_inc
);

  logic             run_d;
  logic [CNT_W-1:0] count_d;
  logic             inc_req;
  logic             zero_req;

  assign zero_req  = tsk.clr | tsk.shut;
  assign count_inc = count_q + 1'b1;

  always_comb begin
    run_d = run_q;
    if (tsk.start)            run_d = 1'b1;
    if (tsk.stop || tsk.shut) run_d = 1'b0;
  end

  always_comb begin
    inc_req = 1'b0;
    if (run_q) begin
      if (mode == MODE_TIMER) inc_req = tick;
      else                    inc_req = tsk.cnt;
    end
  end

  assign inc_fire = inc_req & ~zero_req;

  always_comb begin
    count_d = count_q;
    if (zero_req)      count_d = '0;
    else if (inc_fire) count_d = count_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      count_q <= '0;
    end else begin
      run_q   <= run_d;
      count_q <= count_d;
    end
  end

endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cc_wr,
  input  logic [CNT_W-1:0] cc_wdata,
  input  logic             cap,
  input  logic [CNT_W-1:0] count_q,
  input  logic             inc_fire,
  input  logic [CNT_W-1:0] count_inc,
  input  logic             flg_clr,
  output logic [CNT_W-1:0] cc_q,
  output logic             flag_q
);

  logic [CNT_W-1:0] cc_d;
  logic             flag_d;
  logic             hit;

  assign hit = inc_fire && (count_inc == cc_q);

  always_comb begin
    cc_d = cc_q;
    if (cap)        cc_d = count_q;
    else if (cc_wr) cc_d = cc_wdata;
  end

  always_comb begin
    flag_d = flag_q;
    if (hit)          flag_d = 1'b1;
    else if (flg_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      cc_q   <= cc_d;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/tmr_capture_timer.sv
module tmr_capture_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_CC = 4,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref16_en,
  input  logic              ref1_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  tmr_task_s                    tsk;
  tmr_mode_e                    mode_q, mode_d;
  logic [PRE_W-1:0]             presc_q, presc_d;
  logic                         refsel_q, refsel_d;
  logic [NUM_CC-1:0]            inten_q, inten_d;
  logic                         run_q;
  logic [CNT_W-1:0]             count_q;
  logic [CNT_W-1:0]             count_inc;
  logic                         inc_fire;
  logic                         tick;
  logic                         clr_req;
  logic                         shut_req;
  logic                         trig;
  logic [NUM_CC-1:0]            cap_req;
  logic [NUM_CC-1:0]            cc_wr;
  logic [NUM_CC-1:0]            flg_clr;
  logic [NUM_CC-1:0]            flag_q;
  logic [NUM_CC-1:0][CNT_W-1:0] cc_q;

  // task decode: a write with bit0 = 1 fires the task
  assign trig      = bus_wr & bus_wdata[0];
  assign tsk.start = trig && (bus_addr == ADR_START);
  assign tsk.stop  = trig && (bus_addr == ADR_STOP);
  assign tsk.cnt   = trig && (bus_addr == ADR_COUNT);
  assign tsk.clr   = trig && (bus_addr == ADR_CLEAR);
  assign tsk.shut  = trig && (bus_addr == ADR_SHUT);
  assign clr_req   = tsk.clr;
  assign shut_req  = tsk.shut;

  // configuration registers
  always_comb begin
    mode_d   = mode_q;
    presc_d  = presc_q;
    refsel_d = refsel_q;
    inten_d  = inten_q;
    if (bus_wr) begin
      if (bus_addr == ADR_MODE)    mode_d   = tmr_mode_e'(bus_wdata[0]);
      if (bus_addr == ADR_PRESC)   presc_d  = bus_wdata[PRE_W-1:0];
      if (bus_addr == ADR_REFSEL)  refsel_d = bus_wdata[0];
      if (bus_addr == ADR_IEN_SET) inten_d  = inten_q | bus_wdata[NUM_CC-1:0];
      if (bus_addr == ADR_IEN_CLR) inten_d  = inten_q & ~bus_wdata[NUM_CC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_TIMER;
      presc_q  <= '0;
      refsel_q <= 1'b0;
      inten_q  <= '0;
    end else begin
      mode_q   <= mode_d;
      presc_q  <= presc_d;
      refsel_q <= refsel_d;
      inten_q  <= inten_d;
    end
  end

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .restart  (clr_req | shut_req),
    .ref_sel  (refsel_q),
    .ref16_en (ref16_en),
    .ref1_en  (ref1_en),
    .presc    (presc_q),
    .tick     (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tsk       (tsk),
    .mode      (mode_q),
    .tick      (tick),
    .run_q     (run_q),
    .count_q   (count_q),
    .inc_fire  (inc_fire),
    .count_inc (count_inc)
  );

  for (genvar n = 0; n < NUM_CC; n++) begin : g_chan
    assign cap_req[n] = trig && (bus_addr == ADR_CAP + 8'(n));
    assign cc_wr[n]   = bus_wr && (bus_addr == ADR_CC + 8'(n));
    assign flg_clr[n] = bus_wr && !bus_wdata[0] && (bus_addr == ADR_EVT + 8'(n));

    tmr_cc_chan #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cc_wr     (cc_wr[n]),
      .cc_wdata  (bus_wdata[CNT_W-1:0]),
      .cap       (cap_req[n]),
      .count_q   (count_q),
      .inc_fire  (inc_fire),
      .count_inc (count_inc),
      .flg_clr   (flg_clr[n]),
      .cc_q      (cc_q[n]),
      .flag_q    (flag_q[n])
    );
  end

  // read back
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADR_MODE)   bus_rdata[0] = mode_q;
    if (bus_addr == ADR_PRESC)  bus_rdata[PRE_W-1:0] = presc_q;
    if (bus_addr == ADR_REFSEL) bus_rdata[0] = refsel_q;
    if (bus_addr == ADR_IEN_SET || bus_addr == ADR_IEN_CLR)
      bus_rdata[NUM_CC-1:0] = inten_q;
    for (int n = 0; n < NUM_CC; n++) begin
      if (bus_addr == ADR_EVT + 8'(n)) bus_rdata[0] = flag_q[n];
      if (bus_addr == ADR_CC + 8'(n))  bus_rdata[CNT_W-1:0] = cc_q[n];
    end
  end

  assign irq = |(flag_q & inten_q);

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W  = 32,
  parameter int NUM_CC = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         run_q,
  input logic [CNT_W-1:0]             count_q,
  input logic                         clr_req,
  input logic                         shut_req,
  input logic [NUM_CC-1:0]            cap_req,
  input logic [NUM_CC-1:0]            flg_clr,
  input logic [NUM_CC-1:0]            flag_q,
  input logic [NUM_CC-1:0]            inten_q,
  input logic [NUM_CC-1:0][CNT_W-1:0] cc_q,
  input logic                         irq
);

  a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr_req && !shut_req) |=> $stable(count_q));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !shut_req) |=>
      (count_q == $past(count_q) || count_q == CNT_W'($past(count_q) + 1'b1)));

  a_r9_shutdown_stops: assert property (@(posedge clk) disable iff (!rst_n)
    shut_req |=> (!run_q && count_q == '0));

  a_r8_clear_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !shut_req) |=> (count_q == '0 && run_q == $past(run_q)));

  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (inten_q == '0) |-> !irq);

  for (genvar n = 0; n < NUM_CC; n++) begin : g_chk
    a_r5_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
      cap_req[n] |=> (cc_q[n] == $past(count_q)));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[n] && !flg_clr[n]) |=> flag_q[n]);
  end

endmodule

bind tmr_capture_timer tmr_checker #(.CNT_W(CNT_W), .NUM_CC(NUM_CC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_q    (run_q),
  .count_q  (count_q),
  .clr_req  (clr_req),
  .shut_req (shut_req),
  .cap_req  (cap_req),
  .flg_clr  (flg_clr),
  .flag_q   (flag_q),
  .inten_q  (inten_q),
  .cc_q     (cc_q),
  .irq      (irq)
);

// File: tb/sim_tmr_capture_timer.sv
module sim_tmr_capture_timer;
  import tmr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int NUM_CC     = 4;
  localparam int PRE_W      = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref16_en, ref1_en, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  sb_ev, sb_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_capture_timer #(.CNT_W(CNT_W), .NUM_CC(NUM_CC), .PRE_W(PRE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ref16_en(ref16_en), .ref1_en(ref1_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(sb_ev);
      #1;
      begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'd0, irq} : bus_rdata;
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
        end
      end
      ->sb_done;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    sb_q.push_back('{1'b0, e, tag});
    ->sb_ev;
    @(sb_done);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    @(negedge clk);
    sb_q.push_back('{1'b1, {31'd0, e}, tag});
    ->sb_ev;
    @(sb_done);
  endtask

  task automatic pulse16(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref16_en = 1'b1;
      @(negedge clk); ref16_en = 1'b0;
    end
  endtask

  task automatic pulse1(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref1_en = 1'b1;
      @(negedge clk); ref1_en = 1'b0;
    end
  endtask

  task automatic count_n(input int n);
    for (int i = 0; i < n; i++) wr(ADR_COUNT, 32'd1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; ref16_en = 1'b0; ref1_en = 1'b0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int n = 0; n < NUM_CC; n++) expect_reg(ADR_CC + 8'(n), 0, "R1 cc reset");
    expect_reg(ADR_EVT + 8'd1, 0, "R1 flag reset");
    expect_reg(ADR_IEN_SET, 0, "R1 enables reset");
    expect_reg(ADR_MODE, 0, "R1 mode reset");
    expect_reg(ADR_PRESC, 0, "R1 prescaler reset");
    expect_reg(ADR_REFSEL, 0, "R1 refsel reset");
    expect_irq(1'b0, "R1 irq reset");
    wr(ADR_CAP, 1);
    expect_reg(ADR_CC, 0, "R1 count reset");

    // R2 timer mode, prescaler and reference select
    wr(ADR_START, 1);
    pulse16(5);
    wr(ADR_CAP, 1);
    expect_reg(ADR_CC, 5, "R2 prescale 0 ticks");
    wr(ADR_STOP, 1);
    wr(ADR_CLEAR, 1);
    wr(ADR_PRESC, 2);
    wr(ADR_START, 1);
    pulse16(8);
    wr(ADR_CAP + 8'd1, 1);
    expect_reg(ADR_CC + 8'd1, 2, "R2 prescale 2 divides by 4");
    pulse1(3);
    wr(ADR_CAP + 8'd1, 1);
    expect_reg(ADR_CC + 8'd1, 2, "R2 unselected reference ignored");
    wr(ADR_REFSEL, 1);
    wr(ADR_PRESC, 0);
    wr(ADR_CLEAR, 1);
    pulse1(4);
    wr(ADR_CAP + 8'd2, 1);
    expect_reg(ADR_CC + 8'd2, 4, "R2 1MHz reference counts");
    count_n(1);
    wr(ADR_CAP + 8'd2, 1);
    expect_reg(ADR_CC + 8'd2, 4, "R3 count task ignored in timer mode");

    // R3 counter mode
    wr(ADR_MODE, 1);
    wr(ADR_CLEAR, 1);
    count_n(3);
    wr(ADR_CAP, 1);
    expect_reg(ADR_CC, 3, "R3 count tasks counted");
    pulse16(2);
    pulse1(2);
    wr(ADR_CAP, 1);
    expect_reg(ADR_CC, 3, "R3 strobes ignored in counter mode");

    // R4 pause and resume
    wr(ADR_STOP, 1);
    count_n(2);
    wr(ADR_CAP, 1);
    expect_reg(ADR_CC, 3, "R4 held while stopped");
    wr(ADR_START, 1);
    count_n(1);
    wr(ADR_CAP, 1);
    expect_reg(ADR_CC, 4, "R4 resumes from held value");

    // R8 clear keeps running
    wr(ADR_CLEAR, 1);
    wr(ADR_CAP + 8'd1, 1);
    expect_reg(ADR_CC + 8'd1, 0, "R8 clear zeroes count");
    count_n(1);
    wr(ADR_CAP + 8'd1, 1);
    expect_reg(ADR_CC + 8'd1, 1, "R8 still running after clear");

    // R5 capture in the same cycle as a tick
    wr(ADR_MODE, 0);
    wr(ADR_REFSEL, 0);
    wr(ADR_CLEAR, 1);
    pulse16(3);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADR_CAP + 8'd3; bus_wdata = 1; ref16_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ref16_en = 1'b0;
    expect_reg(ADR_CC + 8'd3, 3, "R5 capture keeps pre-increment value");
    wr(ADR_CAP + 8'd2, 1);
    expect_reg(ADR_CC + 8'd2, 4, "R5 increment still applied");

    // R6 match flags
    wr(ADR_MODE, 1);
    wr(ADR_CLEAR, 1);
    wr(ADR_CC, 200);
    wr(ADR_CC + 8'd1, 2);
    wr(ADR_CC + 8'd2, 200);
    wr(ADR_CC + 8'd3, 200);
    for (int n = 0; n < NUM_CC; n++) wr(ADR_EVT + 8'(n), 0);
    expect_reg(ADR_EVT + 8'd1, 0, "R6 flag cleared");
    count_n(1);
    expect_reg(ADR_EVT + 8'd1, 0, "R6 no match below value");
    count_n(1);
    expect_reg(ADR_EVT + 8'd1, 1, "R6 match sets flag");
    count_n(1);
    expect_reg(ADR_EVT + 8'd1, 1, "R6 flag sticky");
    wr(ADR_EVT + 8'd1, 1);
    expect_reg(ADR_EVT + 8'd1, 1, "R6 writing 1 has no effect");
    expect_reg(ADR_EVT, 0, "R6 other channel untouched");

    // R7 interrupt masking
    expect_irq(1'b0, "R7 masked flag");
    wr(ADR_IEN_SET, 2);
    expect_irq(1'b1, "R7 enabled flag raises irq");
    expect_reg(ADR_IEN_CLR, 2, "R7 enable readback");
    wr(ADR_IEN_SET, 1);
    wr(ADR_IEN_CLR, 2);
    expect_reg(ADR_IEN_SET, 1, "R7 set and clear");
    expect_irq(1'b0, "R7 cleared enable drops irq");
    wr(ADR_EVT + 8'd1, 0);
    expect_reg(ADR_EVT + 8'd1, 0, "R6 write 0 clears flag");

    // R10 wrap
    wr(ADR_CLEAR, 1);
    wr(ADR_CC, 0);
    wr(ADR_EVT, 0);
    count_n(255);
    wr(ADR_CAP + 8'd1, 1);
    expect_reg(ADR_CC + 8'd1, 255, "R10 all ones reached");
    expect_reg(ADR_EVT, 0, "R10 no match before wrap");
    count_n(1);
    wr(ADR_CAP + 8'd1, 1);
    expect_reg(ADR_CC + 8'd1, 0, "R10 wraps to zero");
    expect_reg(ADR_EVT, 1, "R10 wrap matches zero");
    expect_irq(1'b1, "R7 irq from channel 0");

    // R9 shutdown
    count_n(2);
    wr(ADR_SHUT, 1);
    count_n(1);
    wr(ADR_CAP, 1);
    expect_reg(ADR_CC, 0, "R9 shutdown stops and zeroes");
    wr(ADR_START, 1);
    count_n(1);
    wr(ADR_CAP, 1);
    expect_reg(ADR_CC, 1, "R9 restart counts from zero");

    done = 1'b1;
    finish_run();
  end

endmodule